// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block is a behavioural synchronous burst SRAM. It has a parameterised depth and a word built from four 8-bit byte lanes. On every rising clock edge it samples three chip selects, two address strobes, a burst-advance input and a two-level write decode. From these it classifies the cycle as a deselect, a burst start at the external address, a burst continue or a burst suspend. It then writes the selected lanes into its internal array, or reads a word back onto a modelled tri-state bus. The bus is modelled as a separate input, a separate output and an output-enable flag.

The two strobes are treated differently. The processor-side strobe is gated by the primary chip select and always starts a read. The controller-side strobe starts a read or a write according to the write decode. The secondary selects are sampled only on cycles where a strobe is present.

Burst address sequencing belongs to an attached counter. The block presents its current burst address. The counter returns the address that follows it, and the block uses that address on continue cycles.

A mode input selects the read path:
- Flow-through: read data appears right after the sampling edge.
- Pipelined: read data appears one clock later.

The SRAM bus has fixed latency and no back-pressure, so every port is a plain control or data pin and no port uses a valid/ready handshake.

Top module: `burst_sram_ctrl`

## Requirements
- R1: After reset, `dq_oe` is low and no burst is live. Strobe-free cycles neither read nor write until a burst is started.
- R2: `wr_all_n` low writes all four lanes. Otherwise, `byte_en_n` low writes lane n (bits 8n+7:8n) for each `lane_wr_n[n]` that is low. If `byte_en_n` is high, or if all `lane_wr_n` bits are high, the cycle is a read.
- R3: `proc_stb_n` low with `cs_n` low, `cs_hi` high and `cs_lo_n` low starts a burst at `addr_in`. This cycle is always a read, whatever the write inputs are.
- R4: `proc_stb_n` is ignored while `cs_n` is high. Such a cycle is decoded from `ctrl_stb_n` and `adv_n` alone.
- R5: A strobe cycle with the chip not selected is a deselect:
  - `ctrl_stb_n` low with `cs_n` high, `cs_hi` low or `cs_lo_n` high;
  - `proc_stb_n` low with `cs_n` low and either `cs_hi` low or `cs_lo_n` high.

  A deselect neither writes nor drives the bus, and it ends the burst. Continue and suspend cycles do nothing until the next burst start.
- R6: `ctrl_stb_n` low with `proc_stb_n` high and the chip selected starts a burst at `addr_in`. It is a read or a write according to R2.
- R7: With no accepted strobe and `adv_n` low, a live burst continues. The access uses `burst_next`, and `burst_addr` takes that value. The cycle is a read or a write according to R2.
- R8: With no accepted strobe and `adv_n` high, a live burst is suspended. The access repeats `burst_addr`, which stays unchanged.
- R9: `cs_hi` and `cs_lo_n` have no effect on cycles without a low strobe.
- R10: With `pipe_mode` low, read data is on `dq_out` from the sampling edge until the next edge. With `pipe_mode` high, it appears one clock later.
- R11: `dq_oe` is high only while read data is present and `oe_n` is low. `oe_n` acts without a clock edge. Write and deselect cycles leave `dq_oe` low.
- R12: While `sleep` is high, no cycle is accepted, no lane is written and the burst address is held. Array contents are kept.
- R13: In pipelined mode, a read issued just before a deselect still appears on the bus for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_in | input | AW | External address for burst starts |
| burst_addr | output | AW | Current burst address, sent to the attached counter |
| burst_next | input | AW | Following address, returned by the attached counter |
| proc_stb_n | input | 1 | Processor-side address strobe, active low |
| ctrl_stb_n | input | 1 | Controller-side address strobe, active low |
| cs_n | input | 1 | Primary chip select, active low |
| cs_hi | input | 1 | Secondary chip select, active high |
| cs_lo_n | input | 1 | Secondary chip select, active low |
| adv_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Write all lanes, active low |
| byte_en_n | input | 1 | Per-lane write enable qualifier, active low |
| lane_wr_n | input | LANES | Per-lane write selects, active low |
| pipe_mode | input | 1 | 1 = pipelined read path, 0 = flow-through |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Standby request |
| dq_in | input | LANES*LANE_W | Write data from the bus |
| dq_out | output | LANES*LANE_W | Read data toward the bus |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The assertions assume that `pipe_mode` stays steady around a read. They also assume that `burst_next` is a pure function of `burst_addr`, so it cannot change while a suspended burst is held. The bench sets `pipe_mode` only after deselect cycles have emptied both read stages. It models the attached counter as a combinational wrap within an aligned group of four words. All inputs change on the falling edge, so every decoded cycle sees settled strobes, selects and write controls.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  typedef enum logic [2:0] {
    CYC_IDLE,
    CYC_DESEL,
    CYC_BEGIN,
    CYC_CONT,
    CYC_HOLD
  } cyc_e;
endpackage

// File: rtl/bsr_cycle_decode.sv
module bsr_cycle_decode
  import bsr_pkg::*;
(
  input  logic sleep,
  input  logic proc_stb_n,
  input  logic ctrl_stb_n,
  input  logic cs_n,
  input  logic cs_hi,
  input  logic cs_lo_n,
  input  logic adv_n,
  output cyc_e cyc,
  output logic forced_read
);
  logic chip_on;
  logic proc_seen;

  assign chip_on   = !cs_n && cs_hi && !cs_lo_n;
  // processor strobe only counts while the primary select is low
  assign proc_seen = !proc_stb_n && !cs_n;

  always_comb begin
    cyc         = CYC_IDLE;
    forced_read = 1'b0;
    if (sleep) begin
      cyc = CYC_IDLE;
    end else if (proc_seen) begin
      cyc         = chip_on ? CYC_BEGIN : CYC_DESEL;
      forced_read = chip_on;
    end else if (!ctrl_stb_n) begin
      cyc = chip_on ? CYC_BEGIN : CYC_DESEL;
    end else begin
      cyc = adv_n ? CYC_HOLD : CYC_CONT;
    end
  end
endmodule

// File: rtl/bsr_lane_mask.sv
module bsr_lane_mask #(
  parameter int LANES = 4
) (
  input  logic             wr_all_n,
  input  logic             byte_en_n,
  input  logic [LANES-1:0] lane_wr_n,
  output logic [LANES-1:0] lanes
);
  always_comb begin
    if (!wr_all_n)       lanes = '1;
    else if (!byte_en_n) lanes = ~lane_wr_n;
    else                 lanes = '0;
  end
endmodule

// File: rtl/bsr_array.sv
module bsr_array #(
  parameter int AW     = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        we,
  input  logic [AW-1:0]           waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [AW-1:0]           raddr,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (we[g]) store[waddr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = store[raddr];
  end
endmodule

// File: rtl/bsr_out_stage.sv
module bsr_out_stage #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pipe_mode,
  input  logic          rd_valid,
  input  logic [DW-1:0] rd_data,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  logic          v2;
  logic [DW-1:0] d2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v2 <= 1'b0;
      d2 <= '0;
    end else begin
      v2 <= rd_valid;
      if (rd_valid) d2 <= rd_data;
    end
  end

  assign out_valid = pipe_mode ? v2 : rd_valid;
  assign out_data  = pipe_mode ? d2 : rd_data;

  // R10: a pipelined read shows up exactly one edge later
  p_pipe_delay_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && rd_valid) |=> (!pipe_mode || out_valid));

  // R10: flow-through output tracks the first stage directly
  p_flow_now_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && !rd_valid) |-> !out_valid);
endmodule

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import bsr_pkg::*;
#(
  parameter int AW     = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [AW-1:0]           addr_in,
  output logic [AW-1:0]           burst_addr,
  input  logic [AW-1:0]           burst_next,
  input  logic                    proc_stb_n,
  input  logic                    ctrl_stb_n,
  input  logic                    cs_n,
  input  logic                    cs_hi,
  input  logic                    cs_lo_n,
  input  logic                    adv_n,
  input  logic                    wr_all_n,
  input  logic                    byte_en_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic                    pipe_mode,
  input  logic                    oe_n,
  input  logic                    sleep,
  input  logic [LANES*LANE_W-1:0] dq_in,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic                    dq_oe
);
  localparam int DW = LANES * LANE_W;

  cyc_e             cyc;
  logic             forced_read;
  logic [LANES-1:0] lanes_req;
  logic [LANES-1:0] lanes_eff;
  logic             burst_live;
  logic             acting;
  logic             is_read;
  logic [AW-1:0]    acc_addr;
  logic             rd_v1;
  logic [AW-1:0]    rd_addr_q;
  logic [DW-1:0]    arr_rdata;
  logic             out_valid;

  bsr_cycle_decode u_decode (
    .sleep       (sleep),
    .proc_stb_n  (proc_stb_n),
    .ctrl_stb_n  (ctrl_stb_n),
    .cs_n        (cs_n),
    .cs_hi       (cs_hi),
    .cs_lo_n     (cs_lo_n),
    .adv_n       (adv_n),
    .cyc         (cyc),
    .forced_read (forced_read)
  );

  bsr_lane_mask #(.LANES(LANES)) u_mask (
    .wr_all_n  (wr_all_n),
    .byte_en_n (byte_en_n),
    .lane_wr_n (lane_wr_n),
    .lanes     (lanes_req)
  );

  always_comb begin
    acting = (cyc == CYC_BEGIN) ||
             (burst_live && (cyc == CYC_CONT || cyc == CYC_HOLD));
    unique case (cyc)
      CYC_BEGIN: acc_addr = addr_in;
      CYC_CONT:  acc_addr = burst_next;
      default:   acc_addr = burst_addr;
    endcase
    lanes_eff = (acting && !forced_read) ? lanes_req : '0;
    is_read   = acting && (lanes_eff == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_live <= 1'b0;
      burst_addr <= '0;
      rd_v1      <= 1'b0;
      rd_addr_q  <= '0;
    end else begin
      rd_v1 <= is_read;
      if (is_read) rd_addr_q <= acc_addr;
      case (cyc)
        CYC_DESEL: burst_live <= 1'b0;
        CYC_BEGIN: begin
          burst_live <= 1'b1;
          burst_addr <= addr_in;
        end
        CYC_CONT: if (burst_live) burst_addr <= burst_next;
        default: ;
      endcase
    end
  end

  bsr_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk   (clk),
    .we    (lanes_eff),
    .waddr (acc_addr),
    .wdata (dq_in),
    .raddr (rd_addr_q),
    .rdata (arr_rdata)
  );

  bsr_out_stage #(.DW(DW)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .pipe_mode (pipe_mode),
    .rd_valid  (rd_v1),
    .rd_data   (arr_rdata),
    .out_valid (out_valid),
    .out_data  (dq_out)
  );

  assign dq_oe = out_valid && !oe_n;

  // R3: an accepted processor strobe never writes the array
  p_proc_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !proc_stb_n && !cs_n && cs_hi && !cs_lo_n) |-> (lanes_eff == '0));

  // R5: a deselect leaves nothing in flight and kills the burst
  p_desel_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == CYC_DESEL) |=> (!burst_live && !rd_v1));

  // R8: a suspend keeps the burst address
  p_hold_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == CYC_HOLD) |=> $stable(burst_addr));

  // R11: a flow-through write cycle never drives the bus next
  p_write_no_drive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && (lanes_eff != '0)) |=> (pipe_mode || !dq_oe));

  // R12: standby accepts no write and freezes the burst address
  p_sleep_nowrite_r12: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (lanes_eff == '0));
  p_sleep_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> $stable(burst_addr));
endmodule

// File: tb/burst_sram_ctrl_test.sv
`timescale 1ns/1ps
module burst_sram_ctrl_test;
  localparam int AW = 8;
  localparam int LANES = 4;
  localparam int LANE_W = 8;
  localparam int DW = LANES * LANE_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] burst_addr;
  logic [AW-1:0] burst_next;
  logic proc_stb_n = 1'b1, ctrl_stb_n = 1'b1, cs_n = 1'b1, cs_hi = 1'b1;
  logic cs_lo_n = 1'b0, adv_n = 1'b1, wr_all_n = 1'b1, byte_en_n = 1'b1;
  logic [LANES-1:0] lane_wr_n = '1;
  logic pipe_mode = 1'b0, oe_n = 1'b0, sleep = 1'b0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic dq_oe;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  // attached counter model: wrap within an aligned group of four
  assign burst_next = {burst_addr[AW-1:2], burst_addr[1:0] + 2'd1};

  burst_sram_ctrl #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) uut (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .burst_addr(burst_addr),
    .burst_next(burst_next), .proc_stb_n(proc_stb_n), .ctrl_stb_n(ctrl_stb_n),
    .cs_n(cs_n), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n), .adv_n(adv_n),
    .wr_all_n(wr_all_n), .byte_en_n(byte_en_n), .lane_wr_n(lane_wr_n),
    .pipe_mode(pipe_mode), .oe_n(oe_n), .sleep(sleep), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_cmd(input logic pn, input logic cn, input logic csn,
                         input logic chi, input logic clon, input logic an,
                         input logic gwn, input logic ben, input logic [3:0] lw,
                         input logic [AW-1:0] a, input logic [DW-1:0] d);
    proc_stb_n = pn; ctrl_stb_n = cn; cs_n = csn; cs_hi = chi; cs_lo_n = clon;
    adv_n = an; wr_all_n = gwn; byte_en_n = ben; lane_wr_n = lw;
    addr_in = a; dq_in = d;
  endtask

  task automatic wr_ctrl(input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic gwn, input logic ben, input logic [3:0] lw);
    set_cmd(1, 0, 0, 1, 0, 1, gwn, ben, lw, a, d);
    tick();
  endtask

  task automatic rd_ctrl(input logic [AW-1:0] a);
    set_cmd(1, 0, 0, 1, 0, 1, 1, 1, 4'hF, a, '0);
    tick();
  endtask

  task automatic desel();
    set_cmd(1, 0, 1, 1, 0, 1, 1, 1, 4'hF, '0, '0);
    tick();
  endtask

  task automatic step(input logic an, input logic gwn, input logic [DW-1:0] d);
    set_cmd(1, 1, 0, 1, 0, an, gwn, 1, 4'hF, '0, d);
    tick();
  endtask

  task automatic chk(input string rq, input logic eoe, input logic [DW-1:0] ed);
    checks++;
    if (dq_oe !== eoe || (eoe && dq_out !== ed)) begin
      failures++;
      $display("FAIL %s: oe=%b data=%h expected oe=%b data=%h", rq, dq_oe, dq_out, eoe, ed);
    end
  endtask

  task automatic chk_addr(input string rq, input logic [AW-1:0] ea);
    checks++;
    if (burst_addr !== ea) begin
      failures++;
      $display("FAIL %s: burst_addr=%h expected %h", rq, burst_addr, ea);
    end
  endtask

  task automatic t_reset();
    chk("R1 no drive after reset", 0, '0);
    chk_addr("R1 burst address after reset", '0);
    step(0, 0, 32'h1234_5678);
    chk("R1 continue without burst is inert", 0, '0);
  endtask

  task automatic t_write_decode();
    wr_ctrl(8'd5, 32'hA5A5_1234, 0, 1, 4'hF);
    chk("R11 write cycle leaves bus off", 0, '0);
    rd_ctrl(8'd5);
    chk("R6 R2 full write read back", 1, 32'hA5A5_1234);
    wr_ctrl(8'd5, 32'hFFFF_FFFF, 1, 0, 4'b1011);
    rd_ctrl(8'd5);
    chk("R2 lane 2 only", 1, 32'hA5FF_1234);
    wr_ctrl(8'd5, 32'h0, 1, 1, 4'h0);
    chk("R2 byte_en_n high is a read", 1, 32'hA5FF_1234);
    wr_ctrl(8'd5, 32'h0, 1, 0, 4'hF);
    chk("R2 no lane selected is a read", 1, 32'hA5FF_1234);
    wr_ctrl(8'd5, 32'h0000_00EE, 1, 0, 4'b1110);
    rd_ctrl(8'd5);
    chk("R2 lane 0 only", 1, 32'hA5FF_12EE);
  endtask

  task automatic t_proc_read();
    wr_ctrl(8'd9, 32'h1111_2222, 0, 1, 4'hF);
    set_cmd(0, 1, 0, 1, 0, 1, 0, 0, 4'h0, 8'd9, 32'hDEAD_BEEF);
    tick();
    chk("R3 processor strobe reads despite write inputs", 1, 32'h1111_2222);
    rd_ctrl(8'd9);
    chk("R3 no write happened", 1, 32'h1111_2222);
  endtask

  task automatic t_burst();
    for (int i = 12; i < 16; i++) wr_ctrl(AW'(i), 32'hC0DE_0000 | i, 0, 1, 4'hF);
    rd_ctrl(8'd14);
    chk("R6 burst start read", 1, 32'hC0DE_000E);
    step(0, 1, '0);
    chk("R7 continue to next", 1, 32'hC0DE_000F);
    step(0, 1, '0);
    chk("R7 continue wraps", 1, 32'hC0DE_000C);
    chk_addr("R7 burst address follows", 8'd12);
    step(1, 1, '0);
    chk("R8 suspend repeats", 1, 32'hC0DE_000C);
    chk_addr("R8 suspend holds address", 8'd12);
    set_cmd(0, 1, 1, 1, 0, 0, 1, 1, 4'hF, 8'd40, '0);
    tick();
    chk("R4 processor strobe ignored with cs_n high", 1, 32'hC0DE_000D);
    step(0, 0, 32'h0000_0077);
    chk("R7 continue write leaves bus off", 0, '0);
    rd_ctrl(8'd14);
    chk("R7 continue write landed", 1, 32'h0000_0077);
  endtask

  task automatic t_desel();
    rd_ctrl(8'd12);
    chk("R6 read 12", 1, 32'hC0DE_000C);
    set_cmd(1, 1, 0, 0, 1, 0, 1, 1, 4'hF, '0, '0);
    tick();
    chk("R9 secondary selects ignored without strobe", 1, 32'hC0DE_000D);
    set_cmd(1, 0, 0, 0, 0, 1, 1, 1, 4'hF, 8'd12, '0);
    tick();
    chk("R5 control strobe deselect", 0, '0);
    step(0, 0, 32'h5555_5555);
    chk("R5 continue after deselect inert", 0, '0);
    step(1, 1, '0);
    chk("R5 suspend after deselect inert", 0, '0);
    rd_ctrl(8'd12);
    set_cmd(0, 1, 0, 1, 1, 1, 1, 1, 4'hF, 8'd12, '0);
    tick();
    chk("R5 processor strobe deselect", 0, '0);
    rd_ctrl(8'd14);
    chk("R5 no write after deselect", 1, 32'h0000_0077);
  endtask

  task automatic t_oe();
    oe_n = 1'b1;
    rd_ctrl(8'd12);
    chk("R11 oe_n high blocks drive", 0, '0);
    oe_n = 1'b0;
    #0.5;
    chk("R11 oe_n acts without clock", 1, 32'hC0DE_000C);
    oe_n = 1'b1;
    #0.5;
    chk("R11 oe_n release without clock", 0, '0);
    oe_n = 1'b0;
  endtask

  task automatic t_pipe();
    desel();
    desel();
    pipe_mode = 1'b1;
    rd_ctrl(8'd5);
    chk("R10 pipelined data not yet out", 0, '0);
    desel();
    chk("R13 data drains through deselect", 1, 32'hA5FF_12EE);
    desel();
    chk("R10 bus off after drain", 0, '0);
    rd_ctrl(8'd12);
    chk("R10 pipelined burst first slot empty", 0, '0);
    step(0, 1, '0);
    chk("R10 pipelined word one", 1, 32'hC0DE_000C);
    desel();
    chk("R13 pipelined word two drains", 1, 32'hC0DE_000D);
    desel();
    chk("R10 pipelined bus off", 0, '0);
    pipe_mode = 1'b0;
  endtask

  task automatic t_sleep();
    rd_ctrl(8'd14);
    chk("R6 read before standby", 1, 32'h0000_0077);
    sleep = 1'b1;
    wr_ctrl(8'd14, 32'h9999_9999, 0, 1, 4'hF);
    chk("R12 no read cycle in standby", 0, '0);
    step(0, 1, '0);
    chk_addr("R12 burst address held", 8'd14);
    sleep = 1'b0;
    step(1, 1, '0);
    chk("R12 contents and burst kept", 1, 32'h0000_0077);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_decode();
    t_proc_read();
    t_burst();
    t_desel();
    t_oe();
    t_pipe();
    t_sleep();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule